// File: doc/BRIEF.md
# Two-Level Register File Cache

This block serves operand reads for an out-of-order core from two storage levels. A large main bank keeps every physical register and answers in two cycles through a pipelined read. A small, fully associative cache bank keeps a subset of the registers and answers in one cycle. Each issue-side read port reports, one cycle after its request, whether the tag was found in the cache. A hit returns the cached value at once. A miss is followed one cycle later by the value from the main bank, qualified by its own strobe.

Entries are placed in the cache according to how a value is consumed, not according to its address. Write-backs always go to the main bank and refresh any cached copy. A write-back allocates a cache entry only when its value was not already delivered through the bypass network, since most values are read at most once. A separate insertion input copies a register from the main bank into the cache. The issue logic drives it for operands of instructions that are ready but still waiting. At most one entry is allocated per cycle. When the cache is full, entries that have already been read are evicted first, oldest first. If none has been read, the oldest entry is evicted.

Top module: `twolevel_rf`

## Requirements
- R1: While reset is asserted and after it is released, the cache is empty, so every read misses, and no hit, miss or slow strobe is raised without a request.
- R2: A read whose tag is in the cache raises its hit strobe with the cached value exactly one cycle after the request, and raises no miss.
- R3: A read whose tag is not cached raises its miss strobe one cycle after the request, then the slow strobe with the main-bank value two cycles after the request.
- R4: Both read paths return the value a register held before any write-back issued in the same cycle as the read.
- R5: A write-back always updates the main bank, and also updates a cached copy of the same tag whether or not it was bypassed.
- R6: A write-back flagged as bypassed never allocates a cache entry.
- R7: A write-back not flagged as bypassed, whose tag is not cached, allocates an entry, so that the next read of that tag hits.
- R8: The insertion input allocates an entry filled from the main bank. It has no effect when the tag is already cached or when any write-back in the same cycle carries the same tag.
- R9: At most one entry is allocated per cycle. The lowest-numbered qualifying write-back port wins, and the insertion input comes last. Occupied entries become empty only at reset.
- R10: With the cache full and no entry read since it was allocated, an allocation evicts the entry allocated longest ago.
- R11: With the cache full and at least one entry read (a hit) since its allocation, an allocation evicts the oldest of the entries that have been read.
- R12: Updating a cached entry through a write-back changes neither its age nor its read status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | NRD | Read request per port |
| rd_tag | input | NRD x TW | Physical register tag per read port |
| rd_hit | output | NRD | Cache hit, one cycle after request |
| rd_miss | output | NRD | Cache miss, one cycle after request |
| rd_fdata | output | NRD x DW | Cached value, valid with rd_hit |
| rd_slow_vld | output | NRD | Main-bank value valid, two cycles after a missing request |
| rd_slow_data | output | NRD x DW | Main-bank value |
| wb_en | input | NWB | Write-back valid per port |
| wb_tag | input | NWB x TW | Write-back destination tag |
| wb_data | input | NWB x DW | Write-back value |
| wb_byp | input | NWB | Value was already consumed through the bypass network |
| ins_en | input | 1 | Request to copy a register into the cache |
| ins_tag | input | TW | Tag to copy |

## Verification
The hardest situation to reach is a full cache that mixes read and unread entries of known ages, because eviction order is visible only through later hits and misses. The stimulus resets the cache and fills all sixteen entries through the insertion input. It then marks chosen entries read by hitting them, refreshes others through bypassed write-backs, and forces further allocations. Reads afterwards show which tag left. A long random phase on a narrow tag range then keeps the cache under constant eviction while reads, write-backs and insertions collide on the same tags.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  // Source that wins the single allocation slot of a cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_WB   = 2'd1,
    SRC_INS  = 2'd2
  } alloc_src_e;

endpackage

// File: rtl/rfc_main_bank.sv
module rfc_main_bank #(
  parameter int NPREG = 128,
  parameter int DW    = 32,
  parameter int NRD   = 2,
  parameter int NWB   = 2,
  parameter int TW    = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0]           rd_go,
  input  logic [NRD-1:0][TW-1:0]   rd_tag,
  input  logic [NWB-1:0]           wb_en,
  input  logic [NWB-1:0][TW-1:0]   wb_tag,
  input  logic [NWB-1:0][DW-1:0]   wb_data,
  input  logic [TW-1:0]            ins_tag,
  output logic [DW-1:0]            ins_rdata,
  output logic [NRD-1:0]           slow_vld,
  output logic [NRD-1:0][DW-1:0]   slow_data
);

  logic [DW-1:0]          mem [NPREG];
  logic [NRD-1:0]         s1_v;
  logic [NRD-1:0][DW-1:0] s1_d;
  logic [NRD-1:0]         s2_v;
  logic [NRD-1:0][DW-1:0] s2_d;

  // storage: every write-back lands here
  always_ff @(posedge clk) begin
    for (int i = 0; i < NWB; i++) begin
      if (wb_en[i]) mem[wb_tag[i]] <= wb_data[i];
    end
  end

  assign ins_rdata = mem[ins_tag];

  // two-stage read pipe, valid bits under reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= '0;
      s2_v <= '0;
    end else begin
      s1_v <= rd_go;
      s2_v <= s1_v;
    end
  end

  // data stages, enabled by their valid
  always_ff @(posedge clk) begin
    for (int p = 0; p < NRD; p++) begin
      if (rd_go[p]) s1_d[p] <= mem[rd_tag[p]];
      if (s1_v[p])  s2_d[p] <= s1_d[p];
    end
  end

  assign slow_vld  = s2_v;
  assign slow_data = s2_d;

endmodule

// File: rtl/rfc_victim_sel.sv
module rfc_victim_sel #(
  parameter int NC         = 16,
  parameter int CW         = 4,
  parameter bit READ_FIRST = 1'b1
) (
  input  logic [NC-1:0]         valid,
  input  logic [NC-1:0]         was_read,
  input  logic [NC-1:0][CW-1:0] age,
  output logic [CW-1:0]         victim
);

  logic          any_free;
  logic          any_read;
  logic          have;
  logic [CW-1:0] best_age;

  assign any_read = |(valid & was_read);

  always_comb begin
    victim   = '0;
    any_free = 1'b0;
    have     = 1'b0;
    best_age = '0;
    // lowest free slot first
    for (int e = NC - 1; e >= 0; e--) begin
      if (!valid[e]) begin
        any_free = 1'b1;
        victim   = CW'(e);
      end
    end
    // full: oldest among candidates (read entries if any, else all)
    if (!any_free) begin
      for (int e = 0; e < NC; e++) begin
        if ((!(READ_FIRST && any_read) || was_read[e]) &&
            (!have || age[e] > best_age)) begin
          have     = 1'b1;
          best_age = age[e];
          victim   = CW'(e);
        end
      end
    end
  end

endmodule

// File: rtl/rfc_cache_bank.sv
module rfc_cache_bank
  import rfc_pkg::*;
#(
  parameter int NC         = 16,
  parameter int DW         = 32,
  parameter int NRD        = 2,
  parameter int NWB        = 2,
  parameter int TW         = 7,
  parameter int CW         = 4,
  parameter bit READ_FIRST = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0]           rd_req,
  input  logic [NRD-1:0][TW-1:0]   rd_tag,
  input  logic [NWB-1:0]           wb_en,
  input  logic [NWB-1:0][TW-1:0]   wb_tag,
  input  logic [NWB-1:0][DW-1:0]   wb_data,
  input  logic [NWB-1:0]           wb_byp,
  input  logic                     ins_en,
  input  logic [TW-1:0]            ins_tag,
  input  logic [DW-1:0]            ins_rdata,
  output logic [NRD-1:0]           lk_hit,
  output logic [NRD-1:0]           hit_q,
  output logic [NRD-1:0]           miss_q,
  output logic [NRD-1:0][DW-1:0]   fdata_q,
  output logic [NC-1:0]            valid_o
);

  // entry state
  logic [NC-1:0]          v_q, v_d;
  logic [NC-1:0]          rd_q, rd_d;
  logic [NC-1:0][CW-1:0]  age_q, age_d;
  logic [TW-1:0]          tag_q  [NC];
  logic [DW-1:0]          data_q [NC];

  // lookup results
  logic [NRD-1:0][CW-1:0] lk_idx;
  logic [NWB-1:0]         wb_hit;
  logic [NWB-1:0][CW-1:0] wb_idx;
  logic                   ins_hit;
  logic                   ins_clash;

  // allocation
  alloc_src_e             alloc_src;
  logic                   alloc_go;
  logic [TW-1:0]          alloc_tag;
  logic [DW-1:0]          alloc_data;
  logic [CW-1:0]          victim;

  // per-entry write port
  logic [NC-1:0]          ent_we;
  logic [NC-1:0]          tag_we;
  logic [NC-1:0][DW-1:0]  ent_wdata;

  // read port tag match
  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      lk_hit[p] = 1'b0;
      lk_idx[p] = '0;
      for (int e = 0; e < NC; e++) begin
        if (v_q[e] && tag_q[e] == rd_tag[p]) begin
          lk_hit[p] = rd_req[p];
          lk_idx[p] = CW'(e);
        end
      end
    end
  end

  // write-back and insertion tag match
  always_comb begin
    ins_hit   = 1'b0;
    ins_clash = 1'b0;
    for (int i = 0; i < NWB; i++) begin
      wb_hit[i] = 1'b0;
      wb_idx[i] = '0;
      for (int e = 0; e < NC; e++) begin
        if (v_q[e] && tag_q[e] == wb_tag[i]) begin
          wb_hit[i] = 1'b1;
          wb_idx[i] = CW'(e);
        end
      end
      if (wb_en[i] && wb_tag[i] == ins_tag) ins_clash = 1'b1;
    end
    for (int e = 0; e < NC; e++) begin
      if (v_q[e] && tag_q[e] == ins_tag) ins_hit = 1'b1;
    end
  end

  // single allocation slot: lowest write-back port, then insertion
  always_comb begin
    alloc_src  = SRC_NONE;
    alloc_tag  = '0;
    alloc_data = '0;
    for (int i = NWB - 1; i >= 0; i--) begin
      if (wb_en[i] && !wb_byp[i] && !wb_hit[i]) begin
        alloc_src  = SRC_WB;
        alloc_tag  = wb_tag[i];
        alloc_data = wb_data[i];
      end
    end
    if (alloc_src == SRC_NONE && ins_en && !ins_hit && !ins_clash) begin
      alloc_src  = SRC_INS;
      alloc_tag  = ins_tag;
      alloc_data = ins_rdata;
    end
  end

  assign alloc_go = (alloc_src != SRC_NONE);

  rfc_victim_sel #(
    .NC(NC), .CW(CW), .READ_FIRST(READ_FIRST)
  ) u_victim (
    .valid    (v_q),
    .was_read (rd_q),
    .age      (age_q),
    .victim   (victim)
  );

  // next state of entries
  always_comb begin
    v_d    = v_q;
    rd_d   = rd_q;
    age_d  = age_q;
    ent_we = '0;
    tag_we = '0;
    for (int e = 0; e < NC; e++) ent_wdata[e] = '0;
    for (int p = 0; p < NRD; p++) begin
      if (lk_hit[p]) rd_d[lk_idx[p]] = 1'b1;
    end
    for (int i = 0; i < NWB; i++) begin
      if (wb_en[i] && wb_hit[i]) begin
        ent_we[wb_idx[i]]    = 1'b1;
        ent_wdata[wb_idx[i]] = wb_data[i];
      end
    end
    if (alloc_go) begin
      for (int e = 0; e < NC; e++) begin
        if (v_q[e] && (!v_q[victim] || age_q[e] < age_q[victim]))
          age_d[e] = age_q[e] + 1'b1;
      end
      v_d[victim]       = 1'b1;
      rd_d[victim]      = 1'b0;
      age_d[victim]     = '0;
      ent_we[victim]    = 1'b1;
      tag_we[victim]    = 1'b1;
      ent_wdata[victim] = alloc_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      rd_q   <= '0;
      age_q  <= '0;
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      v_q    <= v_d;
      rd_q   <= rd_d;
      age_q  <= age_d;
      hit_q  <= lk_hit;
      miss_q <= rd_req & ~lk_hit;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NC; e++) begin
      if (ent_we[e]) data_q[e] <= ent_wdata[e];
      if (tag_we[e]) tag_q[e]  <= alloc_tag;
    end
    for (int p = 0; p < NRD; p++) begin
      if (lk_hit[p]) fdata_q[p] <= data_q[lk_idx[p]];
    end
  end

  assign valid_o = v_q;

endmodule

// File: rtl/twolevel_rf.sv
module twolevel_rf #(
  parameter int NPREG      = 128,
  parameter int NC         = 16,
  parameter int DW         = 32,
  parameter int NRD        = 2,
  parameter int NWB        = 2,
  parameter bit READ_FIRST = 1'b1,
  localparam int TW        = $clog2(NPREG),
  localparam int CW        = $clog2(NC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0]         rd_req,
  input  logic [NRD-1:0][TW-1:0] rd_tag,
  output logic [NRD-1:0]         rd_hit,
  output logic [NRD-1:0]         rd_miss,
  output logic [NRD-1:0][DW-1:0] rd_fdata,
  output logic [NRD-1:0]         rd_slow_vld,
  output logic [NRD-1:0][DW-1:0] rd_slow_data,
  input  logic [NWB-1:0]         wb_en,
  input  logic [NWB-1:0][TW-1:0] wb_tag,
  input  logic [NWB-1:0][DW-1:0] wb_data,
  input  logic [NWB-1:0]         wb_byp,
  input  logic                   ins_en,
  input  logic [TW-1:0]          ins_tag
);

  logic [NRD-1:0] lk_hit;
  logic [DW-1:0]  ins_rdata;
  logic [NC-1:0]  cache_valid;

  rfc_cache_bank #(
    .NC(NC), .DW(DW), .NRD(NRD), .NWB(NWB), .TW(TW), .CW(CW),
    .READ_FIRST(READ_FIRST)
  ) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_tag    (rd_tag),
    .wb_en     (wb_en),
    .wb_tag    (wb_tag),
    .wb_data   (wb_data),
    .wb_byp    (wb_byp),
    .ins_en    (ins_en),
    .ins_tag   (ins_tag),
    .ins_rdata (ins_rdata),
    .lk_hit    (lk_hit),
    .hit_q     (rd_hit),
    .miss_q    (rd_miss),
    .fdata_q   (rd_fdata),
    .valid_o   (cache_valid)
  );

  rfc_main_bank #(
    .NPREG(NPREG), .DW(DW), .NRD(NRD), .NWB(NWB), .TW(TW)
  ) u_main (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_go     (rd_req & ~lk_hit),
    .rd_tag    (rd_tag),
    .wb_en     (wb_en),
    .wb_tag    (wb_tag),
    .wb_data   (wb_data),
    .ins_tag   (ins_tag),
    .ins_rdata (ins_rdata),
    .slow_vld  (rd_slow_vld),
    .slow_data (rd_slow_data)
  );

endmodule

// File: rtl/twolevel_rf_chk.sv
module twolevel_rf_chk #(
  parameter int NRD = 2,
  parameter int NC  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NRD-1:0] rd_req,
  input logic [NRD-1:0] rd_hit,
  input logic [NRD-1:0] rd_miss,
  input logic [NRD-1:0] rd_slow_vld,
  input logic [NC-1:0]  cache_valid
);

  for (genvar p = 0; p < NRD; p++) begin : g_port
    // R2: a request is answered by exactly one of hit or miss
    p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req[p] |=> (rd_hit[p] ^ rd_miss[p]));
    // R1: no strobe without a request
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req[p] |=> (!rd_hit[p] && !rd_miss[p]));
    // R3: every miss is followed by the slow value
    p_slow_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_miss[p] |=> rd_slow_vld[p]);
    // R3: slow value only after a miss
    p_slow_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_slow_vld[p] |-> $past(rd_miss[p]));
  end

  // R9: at most one new occupied entry per cycle
  p_one_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cache_valid) <= $countones($past(cache_valid)) + 1);
  // R9: occupied entries stay occupied
  p_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cache_valid) & ~cache_valid) == '0);

endmodule

bind twolevel_rf twolevel_rf_chk #(.NRD(NRD), .NC(NC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .rd_hit      (rd_hit),
  .rd_miss     (rd_miss),
  .rd_slow_vld (rd_slow_vld),
  .cache_valid (cache_valid)
);

// File: tb/sim_twolevel_rf.sv
module sim_twolevel_rf;

  localparam int CLK_PERIOD = 10;
  localparam int NPREG = 128;
  localparam int NC    = 16;
  localparam int DW    = 32;
  localparam int NRD   = 2;
  localparam int NWB   = 2;
  localparam int TW    = 7;

  logic                   clk;
  logic                   rst_n;
  logic [NRD-1:0]         rd_req;
  logic [NRD-1:0][TW-1:0] rd_tag;
  logic [NRD-1:0]         rd_hit;
  logic [NRD-1:0]         rd_miss;
  logic [NRD-1:0][DW-1:0] rd_fdata;
  logic [NRD-1:0]         rd_slow_vld;
  logic [NRD-1:0][DW-1:0] rd_slow_data;
  logic [NWB-1:0]         wb_en;
  logic [NWB-1:0][TW-1:0] wb_tag;
  logic [NWB-1:0][DW-1:0] wb_data;
  logic [NWB-1:0]         wb_byp;
  logic                   ins_en;
  logic [TW-1:0]          ins_tag;

  twolevel_rf #(
    .NPREG(NPREG), .NC(NC), .DW(DW), .NRD(NRD), .NWB(NWB), .READ_FIRST(1'b1)
  ) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";

  // reference model state
  logic [DW-1:0] m_main [NPREG];
  bit            mv   [NC];
  int            mtag [NC];
  logic [DW-1:0] mdat [NC];
  int            mage [NC];
  bit            mrd  [NC];
  bit            m_s1v [NRD];
  logic [DW-1:0] m_s1d [NRD];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic int find(input int t);
    int r = -1;
    for (int e = 0; e < NC; e++) if (mv[e] && mtag[e] == t) r = e;
    return r;
  endfunction

  function automatic int pick_victim();
    int  v = -1;
    bit  anyr = 0;
    int  best = -1;
    for (int e = NC - 1; e >= 0; e--) if (!mv[e]) v = e;
    if (v >= 0) return v;
    for (int e = 0; e < NC; e++) if (mrd[e]) anyr = 1;
    for (int e = 0; e < NC; e++) begin
      if ((!anyr || mrd[e]) && mage[e] > best) begin
        best = mage[e];
        v = e;
      end
    end
    return v;
  endfunction

  task automatic model_reset();
    for (int e = 0; e < NC; e++) begin mv[e] = 0; mrd[e] = 0; mage[e] = 0; end
    for (int p = 0; p < NRD; p++) m_s1v[p] = 0;
  endtask

  task automatic idle();
    rd_req = '0; wb_en = '0; wb_byp = '0; ins_en = 1'b0;
  endtask

  // one clock: predict, advance, compare at the falling edge
  task automatic cycle();
    bit            n_hit [NRD];
    bit            n_miss [NRD];
    logic [DW-1:0] n_fd [NRD];
    bit            n_s1v [NRD];
    logic [DW-1:0] n_s1d [NRD];
    bit            x_sv [NRD];
    logic [DW-1:0] x_sd [NRD];
    bit            go = 0;
    int            at = 0;
    logic [DW-1:0] ad = '0;
    bit            clash = 0;
    int            vic;
    int            idx;
    for (int p = 0; p < NRD; p++) begin
      idx = find(int'(rd_tag[p]));
      n_hit[p]  = rd_req[p] && idx >= 0;
      n_miss[p] = rd_req[p] && idx < 0;
      n_fd[p]   = (idx >= 0) ? mdat[idx] : '0;
      n_s1v[p]  = n_miss[p];
      n_s1d[p]  = m_main[rd_tag[p]];
    end
    for (int i = 0; i < NWB; i++) begin
      if (!go && wb_en[i] && !wb_byp[i] && find(int'(wb_tag[i])) < 0) begin
        go = 1; at = int'(wb_tag[i]); ad = wb_data[i];
      end
      if (wb_en[i] && wb_tag[i] == ins_tag) clash = 1;
    end
    if (!go && ins_en && find(int'(ins_tag)) < 0 && !clash) begin
      go = 1; at = int'(ins_tag); ad = m_main[ins_tag];
    end
    vic = pick_victim();
    for (int p = 0; p < NRD; p++) begin
      idx = find(int'(rd_tag[p]));
      if (n_hit[p]) mrd[idx] = 1;
    end
    for (int i = 0; i < NWB; i++) begin
      idx = find(int'(wb_tag[i]));
      if (wb_en[i] && idx >= 0) mdat[idx] = wb_data[i];
    end
    if (go) begin
      for (int e = 0; e < NC; e++)
        if (mv[e] && (!mv[vic] || mage[e] < mage[vic])) mage[e]++;
      mv[vic] = 1; mtag[vic] = at; mdat[vic] = ad; mage[vic] = 0; mrd[vic] = 0;
    end
    for (int i = 0; i < NWB; i++) if (wb_en[i]) m_main[wb_tag[i]] = wb_data[i];
    @(posedge clk);
    for (int p = 0; p < NRD; p++) begin
      x_sv[p] = m_s1v[p]; x_sd[p] = m_s1d[p];
      m_s1v[p] = n_s1v[p]; m_s1d[p] = n_s1d[p];
    end
    #1 idle();
    @(negedge clk);
    for (int p = 0; p < NRD; p++) begin
      chk(rd_hit[p] === n_hit[p], "hit strobe", 64'(rd_hit[p]), 64'(n_hit[p]));
      chk(rd_miss[p] === n_miss[p], "miss strobe", 64'(rd_miss[p]), 64'(n_miss[p]));
      if (n_hit[p]) chk(rd_fdata[p] === n_fd[p], "fast data", 64'(rd_fdata[p]), 64'(n_fd[p]));
      chk(rd_slow_vld[p] === x_sv[p], "slow strobe", 64'(rd_slow_vld[p]), 64'(x_sv[p]));
      if (x_sv[p]) chk(rd_slow_data[p] === x_sd[p], "slow data", 64'(rd_slow_data[p]), 64'(x_sd[p]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    chk(rd_hit === '0 && rd_miss === '0 && rd_slow_vld === '0, "strobes in reset",
        64'({rd_hit, rd_miss, rd_slow_vld}), 64'(0));
    rst_n = 1'b1;
  endtask

  task automatic rd2(input int t0, input int t1);
    rd_req = 2'b11; rd_tag[0] = TW'(t0); rd_tag[1] = TW'(t1);
  endtask

  task automatic ins(input int t);
    ins_en = 1'b1; ins_tag = TW'(t);
  endtask

  task automatic wb(input int port, input int t, input logic [DW-1:0] d, input bit byp);
    wb_en[port] = 1'b1; wb_tag[port] = TW'(t); wb_data[port] = d; wb_byp[port] = byp;
  endtask

  initial begin
    rst_n = 1'b0; rd_tag = '0; wb_tag = '0; wb_data = '0; ins_tag = '0;
    idle();
    do_reset();

    // R6: bypassed write-backs fill the main bank without allocating
    cur_req = "R6";
    for (int k = 0; k < NPREG; k += 2) begin
      wb(0, k, 32'hA000_0000 + k, 1'b1);
      wb(1, k + 1, 32'hA000_0000 + k + 1, 1'b1);
      cycle();
    end
    // R1: every read after reset misses
    cur_req = "R1";
    for (int k = 0; k < 8; k++) begin rd2(k, k + 64); cycle(); end
    // R3: slow values arrive two cycles after the request
    cur_req = "R3";
    rd2(3, 77); cycle(); cycle(); cycle();

    // R9: two non-bypassed write-backs, only port 0 allocates
    cur_req = "R9";
    wb(0, 5, 32'h5555_0001, 1'b0); wb(1, 9, 32'h9999_0001, 1'b0); cycle();
    rd2(5, 9); cycle(); cycle();
    wb(1, 20, 32'h2020_0001, 1'b0); ins(30); cycle();
    rd2(20, 30); cycle(); cycle();
    // R7: non-bypassed write-back then hit
    cur_req = "R7";
    wb(1, 9, 32'h9999_0002, 1'b0); cycle();
    rd2(9, 5); cycle();
    // R8: insertion path, repeated and clashing cases
    cur_req = "R8";
    ins(40); cycle();
    ins(40); cycle();
    wb(0, 41, 32'h4141_0001, 1'b1); ins(41); cycle();
    rd2(40, 41); cycle(); cycle();
    // R5: bypassed write to a cached tag refreshes the copy
    cur_req = "R5";
    wb(0, 5, 32'h5555_0002, 1'b1); cycle();
    rd2(5, 30); cycle();
    // R4: read and write of the same tag in one cycle
    cur_req = "R4";
    rd2(5, 60); wb(0, 5, 32'h5555_0003, 1'b1); wb(1, 60, 32'h6060_0001, 1'b1); cycle();
    rd2(5, 60); cycle(); cycle(); cycle();

    // R10: fill sixteen entries, evict the oldest unread
    do_reset();
    cur_req = "R10";
    for (int k = 100; k < 116; k++) begin ins(k); cycle(); end
    ins(116); cycle();
    rd2(100, 116); cycle();
    // R11: read entries are evicted first
    cur_req = "R11";
    rd2(105, 110); cycle();
    ins(117); cycle();
    rd2(105, 110); cycle();
    ins(118); cycle();
    rd2(110, 102); cycle(); cycle();
    // R12: refresh does not change age or read status
    cur_req = "R12";
    wb(0, 103, 32'h1031_0001, 1'b1); cycle();
    ins(119); cycle();
    rd2(103, 104); cycle();
    ins(120); cycle();
    rd2(103, 104); cycle(); cycle();

    // R2: mixed random traffic on a narrow tag range
    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      int t0;
      rd_req = 2'($urandom_range(0, 3));
      rd_tag[0] = TW'($urandom_range(0, 31));
      rd_tag[1] = TW'($urandom_range(0, 31));
      wb_en  = 2'($urandom_range(0, 3));
      wb_byp = 2'($urandom_range(0, 3));
      t0 = $urandom_range(0, 31);
      wb_tag[0] = TW'(t0);
      wb_tag[1] = TW'((t0 + 1 + $urandom_range(0, 30)) % 32);
      wb_data[0] = $urandom;
      wb_data[1] = $urandom;
      ins_en  = 1'($urandom_range(0, 1));
      ins_tag = TW'($urandom_range(0, 31));
      cycle();
    end
    cycle(); cycle();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule